// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits behind a 32-bit host write port and turns narrow host writes into full-width commits towards 128-bit control registers and 64-bit memory words. Partial writes to one wide target are merged in a single collector. The merged value is released as one commit pulse once every dword of that target is present. Registers that are only 32 bits wide bypass the collector and commit at once.

Two write-only pointer registers are handled differently. A write to their top dword always commits, and any lower dword that the collector does not hold for that register is committed as zero. A lower-dword write to a pointer register is dropped when the collector is busy with some other target. A host timer-command write in page 0 flushes the collector. All per-queue registers repeat in pages 8 KiB apart. The block also forwards host reads, and masks reads aimed at the write-only pointer registers.

Top module: `wide_write_collector`

## Requirements
- R1: While rst_ni is low, commit_o and rd_o are 0. After reset the collector is empty, so a first pointer-register top-dword write commits zeros in lanes 0 to 2.
- R2: Offsets below 0x0400 within a page are 128-bit registers, with the dword lane equal to address bits [3:2]. A register commits only once all four lanes are written, in any order. One cycle after the completing write, commit_o is high with commit_kind_o = 2, commit_addr_o equal to the 16-byte aligned base, and lane n in commit_data_o[32n+31:32n].
- R3: A repeated write to a lane that is already held replaces its value and does not commit. The last value written is the one committed.
- R4: A write to a 128-bit register whose base differs from the base held in the collector discards the held lanes. Collection restarts at the new base with only the new lane present.
- R5: A 64-bit write (wr_qword_i = 1, data on wdata_i[63:0]) at byte offset 0 or 8 fills lanes 0/1 or lanes 2/3, with the low half in the lower lane. Two such writes complete a register exactly as four dword writes do.
- R6: Offsets with bit 12 set are 64-bit memory words, with the lane equal to address bit 2. A word commits after both lanes are present, or after a single 64-bit write. The commit has commit_kind_o = 1, an 8-byte aligned address, and zeros in commit_data_o[127:64].
- R7: Any other offset is a 32-bit register. Such a write commits in the next cycle with commit_kind_o = 0, a 4-byte aligned address and the low dword zero-extended. Partial collection of another target is not disturbed.
- R8: Offsets 0x0800 and 0x0A00 are pointer registers. A write that touches their lane 3 always commits with commit_kind_o = 2. Lanes 0 to 2 carry the collected values only if the collector held that same register, and zero otherwise. The collector is empty afterwards.
- R9: A pointer-register write that does not touch lane 3 is dropped when the collector holds lanes of a different target. The held lanes and base stay as they were.
- R10: A 32-bit write to offset 0x0400 in page 0 empties the collector. The same offset in any other page does not.
- R11: The page number is address bits [15:13], with a stride of 0x2000 bytes. Every rule above applies within each page, and commit_addr_o carries the full paged address.
- R12: A read (rd_i) produces rd_o one cycle later with rd_addr_o equal to the read address. Reads of pointer registers leave rd_o at 0. Reads never change the collector.
- R13: commit_o pulses for one cycle for each committing write and is never high without a write in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Host byte address (page and offset) |
| wdata_i | input | 64 | Host write data; the low dword is used for dword writes |
| wr_i | input | 1 | Write strobe |
| wr_qword_i | input | 1 | Write is 64 bits wide, 8-byte aligned |
| rd_i | input | 1 | Read strobe |
| commit_o | output | 1 | One-cycle commit pulse |
| commit_kind_o | output | 2 | 0 dword, 1 memory word, 2 128-bit register |
| commit_addr_o | output | ADDR_W | Aligned address of the committed target |
| commit_data_o | output | 128 | Committed value, zero-extended for narrow targets |
| rd_o | output | 1 | Forwarded read request |
| rd_addr_o | output | ADDR_W | Forwarded read address |

## Verification
The bench aims at collection that is interleaved: a dword register write or a read in the middle of a 128-bit sequence, a 128-bit sequence whose base changes part way, and a lower pointer-register write landing on a busy collector. A design that flushed too eagerly would lose lanes and commit late or never. A design that merged across targets would commit another register's data. The bench also drives a pointer-register top write with an empty or foreign collector, where stale lanes must read as zero, and the timer-command write in page 0 against other pages. Random traffic over several pages mixes every class against a bench-side model.

// File: rtl/wcol_pkg.sv
package wcol_pkg;
  localparam int DW    = 32;
  localparam int NLANE = 4;
  localparam int QW    = 2 * DW;
  localparam int OW    = NLANE * DW;

  typedef enum logic [1:0] {
    CLS_DIRECT = 2'd0,
    CLS_WIDE   = 2'd1,
    CLS_MEM    = 2'd2,
    CLS_DPTR   = 2'd3
  } wr_cls_e;

  typedef enum logic [1:0] {
    KIND_DWORD = 2'd0,
    KIND_QWORD = 2'd1,
    KIND_OWORD = 2'd2
  } cm_kind_e;
endpackage

// File: rtl/wcol_decode.sv
module wcol_decode
  import wcol_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PAGE_W     = 13,
  parameter logic [PAGE_W-1:0] WIDE_LIMIT = 13'h0400,
  parameter logic [PAGE_W-1:0] TMR_OFS    = 13'h0400,
  parameter int unsigned NUM_DPTR   = 2,
  parameter logic [PAGE_W-1:0] DPTR_OFS [NUM_DPTR] = '{13'h0800, 13'h0A00}
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              qword_i,
  output wr_cls_e           cls_o,
  output logic              tmr_pg0_o,
  output logic [NLANE-1:0]  lane_mask_o,
  output logic [ADDR_W-1:0] tag_o,
  output logic [ADDR_W-1:0] dw_addr_o
);
  localparam int unsigned PNUM_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] ofs;
  logic [PNUM_W-1:0] page;
  logic [NUM_DPTR-1:0] dptr_match;
  logic [1:0] lidx;

  assign ofs  = addr_i[PAGE_W-1:0];
  assign page = addr_i[ADDR_W-1:PAGE_W];

  for (genvar g = 0; g < NUM_DPTR; g++) begin : g_dptr
    assign dptr_match[g] = ofs[PAGE_W-1:4] == DPTR_OFS[g][PAGE_W-1:4];
  end

  always_comb begin
    if (ofs[PAGE_W-1])          cls_o = CLS_MEM;
    else if (ofs < WIDE_LIMIT)  cls_o = CLS_WIDE;
    else if (|dptr_match)       cls_o = CLS_DPTR;
    else                        cls_o = CLS_DIRECT;
  end

  // memory words use only two lanes, selected by bit 2
  assign lidx = (cls_o == CLS_MEM) ? {1'b0, addr_i[2]} : addr_i[3:2];

  assign lane_mask_o = qword_i ? (NLANE'(2'b11) << {lidx[1], 1'b0})
                               : (NLANE'(1'b1) << lidx);

  assign tag_o = (cls_o == CLS_MEM) ? {addr_i[ADDR_W-1:3], 3'b000}
                                    : {addr_i[ADDR_W-1:4], 4'b0000};

  assign dw_addr_o = addr_i & ~ADDR_W'(3);

  assign tmr_pg0_o = (page == '0) && (ofs[PAGE_W-1:2] == TMR_OFS[PAGE_W-1:2]);
endmodule

// File: rtl/wcol_collector.sv
module wcol_collector
  import wcol_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              qword_i,
  input  wr_cls_e           cls_i,
  input  logic              tmr_pg0_i,
  input  logic [NLANE-1:0]  lane_mask_i,
  input  logic [ADDR_W-1:0] tag_i,
  input  logic [QW-1:0]     wdata_i,
  output logic              fire_o,
  output logic [OW-1:0]     data_o
);
  logic [NLANE-1:0]  valid_q, valid_d, mrg_valid;
  logic [ADDR_W-1:0] tag_q, tag_d;
  logic [OW-1:0]     data_q, data_d, mrg_data;
  logic              hit, busy;

  assign busy = |valid_q;
  assign hit  = busy && (tag_q == tag_i);

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    localparam bit ODD = (l % 2) == 1;
    logic [DW-1:0] wl;
    assign wl = (qword_i && ODD) ? wdata_i[QW-1:DW] : wdata_i[DW-1:0];
    assign mrg_data[l*DW +: DW] = lane_mask_i[l] ? wl
                                : (hit ? data_q[l*DW +: DW] : '0);
  end

  assign mrg_valid = (hit ? valid_q : '0) | lane_mask_i;

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    data_d  = data_q;
    fire_o  = 1'b0;
    if (wr_i) begin
      case (cls_i)
        CLS_WIDE: begin
          if (&mrg_valid) begin
            fire_o = 1'b1; valid_d = '0; tag_d = '0;
          end else begin
            valid_d = mrg_valid; tag_d = tag_i; data_d = mrg_data;
          end
        end
        CLS_MEM: begin
          if (&mrg_valid[1:0]) begin
            fire_o = 1'b1; valid_d = '0; tag_d = '0;
          end else begin
            valid_d = mrg_valid; tag_d = tag_i; data_d = mrg_data;
          end
        end
        CLS_DPTR: begin
          if (lane_mask_i[NLANE-1]) begin
            fire_o = 1'b1; valid_d = '0; tag_d = '0;
          end else if (!busy || hit) begin
            valid_d = mrg_valid; tag_d = tag_i; data_d = mrg_data;
          end
          // lower lane against a foreign target: dropped
        end
        default: begin
          if (tmr_pg0_i) begin
            valid_d = '0; tag_d = '0;
          end
        end
      endcase
    end
  end

  assign data_o = (cls_i == CLS_MEM) ? {{(OW-QW){1'b0}}, mrg_data[QW-1:0]} : mrg_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      data_q  <= data_d;
    end
  end
endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
  import wcol_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PAGE_W     = 13,
  parameter logic [PAGE_W-1:0] WIDE_LIMIT = 13'h0400,
  parameter logic [PAGE_W-1:0] TMR_OFS    = 13'h0400,
  parameter int unsigned NUM_DPTR   = 2,
  parameter logic [PAGE_W-1:0] DPTR_OFS [NUM_DPTR] = '{13'h0800, 13'h0A00}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [63:0]       wdata_i,
  input  logic              wr_i,
  input  logic              wr_qword_i,
  input  logic              rd_i,
  output logic              commit_o,
  output logic [1:0]        commit_kind_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [127:0]      commit_data_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  wr_cls_e           cls;
  logic              tmr_pg0;
  logic [NLANE-1:0]  lane_mask;
  logic [ADDR_W-1:0] tag, dw_addr;
  logic              col_fire;
  logic [OW-1:0]     col_data;

  wcol_decode #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WIDE_LIMIT(WIDE_LIMIT),
    .TMR_OFS(TMR_OFS), .NUM_DPTR(NUM_DPTR), .DPTR_OFS(DPTR_OFS)
  ) i_decode (
    .addr_i      (addr_i),
    .qword_i     (wr_qword_i),
    .cls_o       (cls),
    .tmr_pg0_o   (tmr_pg0),
    .lane_mask_o (lane_mask),
    .tag_o       (tag),
    .dw_addr_o   (dw_addr)
  );

  wcol_collector #(.ADDR_W(ADDR_W)) i_collector (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .qword_i     (wr_qword_i),
    .cls_i       (cls),
    .tmr_pg0_i   (tmr_pg0),
    .lane_mask_i (lane_mask),
    .tag_i       (tag),
    .wdata_i     (wdata_i),
    .fire_o      (col_fire),
    .data_o      (col_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_o      <= 1'b0;
      commit_kind_o <= KIND_DWORD;
      commit_addr_o <= '0;
      commit_data_o <= '0;
      rd_o          <= 1'b0;
      rd_addr_o     <= '0;
    end else begin
      commit_o <= wr_i && ((cls == CLS_DIRECT) || col_fire);
      if (wr_i && cls == CLS_DIRECT) begin
        commit_kind_o <= KIND_DWORD;
        commit_addr_o <= dw_addr;
        commit_data_o <= {{(OW-DW){1'b0}}, wdata_i[DW-1:0]};
      end else if (wr_i && col_fire) begin
        commit_kind_o <= (cls == CLS_MEM) ? KIND_QWORD : KIND_OWORD;
        commit_addr_o <= tag;
        commit_data_o <= col_data;
      end
      rd_o <= rd_i && (cls != CLS_DPTR);
      if (rd_i) rd_addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/wcol_checker.sv
module wcol_checker
  import wcol_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PAGE_W     = 13,
  parameter logic [PAGE_W-1:0] WIDE_LIMIT = 13'h0400,
  parameter int unsigned NUM_DPTR   = 2,
  parameter logic [PAGE_W-1:0] DPTR_OFS [NUM_DPTR] = '{13'h0800, 13'h0A00}
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [63:0]       wdata_i,
  input logic              wr_i,
  input logic              wr_qword_i,
  input logic              rd_i,
  input logic              commit_o,
  input logic [1:0]        commit_kind_o,
  input logic [ADDR_W-1:0] commit_addr_o,
  input logic [127:0]      commit_data_o,
  input logic              rd_o,
  input logic [ADDR_W-1:0] rd_addr_o
);
  logic in_list, is_mem, is_wide, is_ptr, is_direct, ptr_top;

  always_comb begin
    in_list = 1'b0;
    for (int i = 0; i < NUM_DPTR; i++)
      if (addr_i[PAGE_W-1:4] == DPTR_OFS[i][PAGE_W-1:4]) in_list = 1'b1;
  end

  assign is_mem    = addr_i[PAGE_W-1];
  assign is_wide   = !is_mem && (addr_i[PAGE_W-1:0] < WIDE_LIMIT);
  assign is_ptr    = !is_mem && !is_wide && in_list;
  assign is_direct = !is_mem && !is_wide && !in_list;
  assign ptr_top   = wr_qword_i ? addr_i[3] : (addr_i[3:2] == 2'b11);

  // R1
  always @(posedge clk_i)
    if (!rst_ni) reset_quiet_chk: assert (!commit_o && !rd_o);

  // R7
  direct_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && is_direct) |=> (commit_o && commit_kind_o == 2'd0 &&
                             commit_data_o == {96'b0, $past(wdata_i[31:0])}));

  // R8
  ptr_top_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && is_ptr && ptr_top) |=> (commit_o && commit_kind_o == 2'd2 &&
      commit_addr_o == {$past(addr_i[ADDR_W-1:4]), 4'b0000} &&
      commit_data_o[127:96] == $past(wr_qword_i ? wdata_i[63:32] : wdata_i[31:0])));

  // R13
  commit_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(wr_i));

  // R12
  read_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> ($past(rd_i) && rd_addr_o == $past(addr_i)));

  // R12
  ptr_read_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && is_ptr) |=> !rd_o);

  // R6
  mem_commit_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && commit_kind_o == 2'd1) |->
      (commit_data_o[127:64] == '0 && commit_addr_o[2:0] == 3'b000));

  // R2
  oword_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && commit_kind_o == 2'd2) |-> commit_addr_o[3:0] == 4'h0);
endmodule

bind wide_write_collector wcol_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WIDE_LIMIT(WIDE_LIMIT),
  .NUM_DPTR(NUM_DPTR), .DPTR_OFS(DPTR_OFS)
) i_wcol_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_i(wr_i), .wr_qword_i(wr_qword_i), .rd_i(rd_i), .commit_o(commit_o),
  .commit_kind_o(commit_kind_o), .commit_addr_o(commit_addr_o),
  .commit_data_o(commit_data_o), .rd_o(rd_o), .rd_addr_o(rd_addr_o)
);

// File: tb/test_wide_write_collector.sv
module test_wide_write_collector;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [15:0]  addr_i = '0;
  logic [63:0]  wdata_i = '0;
  logic         wr_i = 1'b0, wr_qword_i = 1'b0, rd_i = 1'b0;
  logic         commit_o, rd_o;
  logic [1:0]   commit_kind_o;
  logic [15:0]  commit_addr_o, rd_addr_o;
  logic [127:0] commit_data_o;

  int vectors = 0;
  int errors  = 0;

  always #4 clk_i = ~clk_i;

  wide_write_collector i_wide_write_collector (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .wr_qword_i(wr_qword_i), .rd_i(rd_i),
    .commit_o(commit_o), .commit_kind_o(commit_kind_o),
    .commit_addr_o(commit_addr_o), .commit_data_o(commit_data_o),
    .rd_o(rd_o), .rd_addr_o(rd_addr_o)
  );

  // bench model of the collector
  logic [31:0] m_lane [4];
  logic [3:0]  m_valid = '0;
  logic [15:0] m_tag = '0;

  // 0 dword, 1 128-bit, 2 memory word, 3 pointer register
  function automatic int cls_of(logic [15:0] a);
    logic [12:0] o;
    o = a[12:0];
    if (o[12]) return 2;
    if (o < 13'h0400) return 1;
    if (o[12:4] == 9'h080 || o[12:4] == 9'h0A0) return 3;
    return 0;
  endfunction

  task automatic check(string tag, string what, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_write(input logic [15:0] a, input bit q, input logic [63:0] d,
                             output bit f, output logic [1:0] k,
                             output logic [15:0] ca, output logic [127:0] cd);
    int c;
    int li;
    logic [15:0] t;
    logic [3:0] wm;
    bit hit;
    c = cls_of(a);
    f = 0; k = 0; ca = 0; cd = 0;
    if (c == 0) begin
      f = 1; k = 0; ca = {a[15:2], 2'b00}; cd = {96'b0, d[31:0]};
      if (a[15:13] == 3'd0 && a[12:2] == 11'h100) begin
        m_valid = '0; m_tag = '0;
      end
      return;
    end
    li = (c == 2) ? int'(a[2]) : int'(a[3:2]);
    t  = (c == 2) ? {a[15:3], 3'b000} : {a[15:4], 4'b0000};
    wm = q ? (4'b0011 << li) : (4'b0001 << li);
    hit = (m_valid != 0) && (m_tag == t);
    if (c == 3 && !wm[3] && m_valid != 0 && !hit) return;
    if (!hit) begin
      m_valid = '0;
      for (int i = 0; i < 4; i++) m_lane[i] = '0;
      m_tag = t;
    end
    m_lane[li] = d[31:0]; m_valid[li] = 1'b1;
    if (q) begin m_lane[li+1] = d[63:32]; m_valid[li+1] = 1'b1; end
    if ((c == 1 && m_valid == 4'hF) || (c == 2 && m_valid[1:0] == 2'b11) || (c == 3 && wm[3])) begin
      f = 1; k = (c == 2) ? 2'd1 : 2'd2; ca = t;
      cd = (c == 2) ? {64'b0, m_lane[1], m_lane[0]}
                    : {m_lane[3], m_lane[2], m_lane[1], m_lane[0]};
      m_valid = '0; m_tag = '0;
    end
  endtask

  task automatic step(string tag, bit wr, bit rd, bit q, logic [15:0] a, logic [63:0] d);
    bit ef;
    bit er;
    logic [1:0] ek;
    logic [15:0] ea;
    logic [127:0] ed;
    ef = 0; ek = 0; ea = 0; ed = 0;
    @(negedge clk_i);
    wr_i = wr; rd_i = rd; wr_qword_i = q; addr_i = a; wdata_i = d;
    if (wr) model_write(a, q, d, ef, ek, ea, ed);
    er = rd && (cls_of(a) != 3);
    @(posedge clk_i);
    #1;
    check(tag, "commit_o", {127'b0, commit_o}, {127'b0, ef});
    if (ef) begin
      check(tag, "commit_kind_o", {126'b0, commit_kind_o}, {126'b0, ek});
      check(tag, "commit_addr_o", {112'b0, commit_addr_o}, {112'b0, ea});
      check(tag, "commit_data_o", commit_data_o, ed);
    end
    check(tag, "rd_o", {127'b0, rd_o}, {127'b0, er});
    if (er) check(tag, "rd_addr_o", {112'b0, rd_addr_o}, {112'b0, a});
  endtask

  task automatic wd(string tag, logic [15:0] a, logic [31:0] d);
    step(tag, 1, 0, 0, a, {32'h0, d});
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 16'h0, 64'h0);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    vectors++;
    $display("FAIL watchdog (R13): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_lane[i] = '0;
    void'($urandom(32'h1c0ffee));
    repeat (3) @(negedge clk_i);
    check("R1", "commit_o in reset", {127'b0, commit_o}, 128'h0);
    check("R1", "rd_o in reset", {127'b0, rd_o}, 128'h0);
    rst_ni = 1'b1;

    // R1: empty collector after reset -> pointer top write carries zero lanes
    wd("R1", 16'h080C, 32'hA1A1_0003);
    idle("R13");

    // R2: lanes in scrambled order
    wd("R2", 16'h0028, 32'h2222_0002);
    wd("R2", 16'h0020, 32'h2222_0000);
    wd("R2", 16'h002C, 32'h2222_0003);
    wd("R2", 16'h0024, 32'h2222_0001);
    idle("R13");

    // R3: repeated lane overwrites
    wd("R3", 16'h0014, 32'h3333_0001);
    wd("R3", 16'h0014, 32'h3333_1111);
    wd("R3", 16'h0010, 32'h3333_0000);
    wd("R3", 16'h0018, 32'h3333_0002);
    wd("R3", 16'h001C, 32'h3333_0003);

    // R4: base change restarts
    wd("R4", 16'h0030, 32'h4444_0000);
    wd("R4", 16'h0034, 32'h4444_0001);
    wd("R4", 16'h0048, 32'h4848_0002);
    wd("R4", 16'h0040, 32'h4848_0000);
    wd("R4", 16'h0044, 32'h4848_0001);
    wd("R4", 16'h004C, 32'h4848_0003);

    // R5: two 64-bit halves
    step("R5", 1, 0, 1, 16'h0058, 64'h5555_0003_5555_0002);
    step("R5", 1, 0, 1, 16'h0050, 64'h5555_0001_5555_0000);

    // R6: memory words
    wd("R6", 16'h100C, 32'h6666_0001);
    wd("R6", 16'h1008, 32'h6666_0000);
    step("R6", 1, 0, 1, 16'h1010, 64'h6767_0001_6767_0000);

    // R7: dword write inside a 128-bit sequence
    wd("R7", 16'h0060, 32'h7777_0000);
    wd("R7", 16'h0404, 32'h7070_7070);
    wd("R7", 16'h0064, 32'h7777_0001);
    wd("R7", 16'h0068, 32'h7777_0002);
    wd("R7", 16'h006C, 32'h7777_0003);

    // R8: pointer register with held lanes
    wd("R8", 16'h0800, 32'h8888_0000);
    wd("R8", 16'h0804, 32'h8888_0001);
    wd("R8", 16'h080C, 32'h8888_0003);

    // R9: lower pointer write against foreign target is dropped
    wd("R9", 16'h0070, 32'h9999_0000);
    wd("R9", 16'h0A04, 32'hDEAD_BEEF);
    wd("R9", 16'h0074, 32'h9999_0001);
    wd("R9", 16'h0078, 32'h9999_0002);
    wd("R9", 16'h007C, 32'h9999_0003);
    wd("R9", 16'h0A0C, 32'h9A9A_0003);

    // R10: timer command page 0 flushes, page 2 does not
    wd("R10", 16'h0080, 32'hAAAA_0000);
    wd("R10", 16'h0084, 32'hAAAA_0001);
    wd("R10", 16'h0400, 32'h0000_0001);
    wd("R10", 16'h0088, 32'hAAAA_0002);
    wd("R10", 16'h008C, 32'hAAAA_0003);
    wd("R10", 16'h0080, 32'hABAB_0000);
    wd("R10", 16'h0084, 32'hABAB_0001);
    wd("R10", 16'h4080, 32'hACAC_0000);
    wd("R10", 16'h4084, 32'hACAC_0001);
    wd("R10", 16'h4400, 32'h0000_0002);
    wd("R10", 16'h4088, 32'hACAC_0002);
    wd("R10", 16'h408C, 32'hACAC_0003);

    // R11: paged pointer register and paged 128-bit register
    wd("R11", 16'hAA00, 32'hBBBB_0000);
    step("R11", 1, 0, 1, 16'hAA08, 64'hBBBB_0003_BBBB_0002);
    wd("R11", 16'hE3F0, 32'hBCBC_0000);
    step("R11", 1, 0, 1, 16'hE3F4, 64'h0);

    // R12: reads forwarded, pointer reads masked, collection intact
    wd("R12", 16'h0090, 32'hCCCC_0000);
    step("R12", 0, 1, 0, 16'h0094, 64'h0);
    step("R12", 0, 1, 0, 16'h2A0C, 64'h0);
    wd("R12", 16'h0094, 32'hCCCC_0001);
    step("R12", 1, 1, 0, 16'h0098, 64'h0000_0000_CCCC_0002);
    wd("R12", 16'h009C, 32'hCCCC_0003);
    idle("R13");

    // random mixed traffic across pages
    for (int n = 0; n < 4000; n++) begin
      int sel;
      bit q;
      bit wr;
      bit rd;
      logic [12:0] o;
      logic [15:0] a;
      logic [63:0] d;
      string tg;
      sel = $urandom % 8;
      q = 0;
      case (sel)
        0: begin o = 13'h0404 + 13'(4 * ($urandom % 4)); tg = "R7"; end
        1: begin o = 13'h0400; tg = "R10"; end
        2, 3, 7: begin
          o = (sel == 7) ? 13'h0030 : (($urandom % 2) ? 13'h0010 : 13'h0020);
          q = ($urandom % 4) == 0;
          o = o + (q ? 13'(8 * ($urandom % 2)) : 13'(4 * ($urandom % 4)));
          tg = "R2";
        end
        4: begin
          o = 13'h1000 + 13'(8 * ($urandom % 2));
          q = ($urandom % 4) == 0;
          if (!q) o = o + 13'(4 * ($urandom % 2));
          tg = "R6";
        end
        default: begin
          o = (sel == 5) ? 13'h0800 : 13'h0A00;
          q = ($urandom % 4) == 0;
          o = o + (q ? 13'(8 * ($urandom % 2)) : 13'(4 * ($urandom % 4)));
          tg = "R8";
        end
      endcase
      a = {3'($urandom % 8), o};
      if (($urandom % 3) == 0) a[15:13] = 3'd0;
      d = {$urandom, $urandom};
      wr = ($urandom % 8) != 0;
      rd = ($urandom % 6) == 0;
      step(tg, wr, rd, q, a, d);
    end
    idle("R13");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule